// File: doc/BRIEF.md
# Edge Interrupt Source Sequencer

This block sits between one edge-signalling interrupt source and the interrupt presentation controller. It detects rising transitions on an asynchronous event line, holds the event as pending, and raises a request that carries the priority and target-CPU binding configured for the source. The controller answers each request with either an accept or a reject.

An accepted request places the source in service. The source is masked implicitly in that state, and it raises nothing more until an end-of-interrupt (EOI) strobe re-arms it. Events that arrive while the source is in service are lost, because there is no replay in hardware. A rejected request is held and offered again after a programmable back-off delay.

A separate explicit mask bit exists for bring-up and tear-down. While this bit is set, no new request is raised. An event that is still pending when the bit is cleared is dropped, so no stale interrupt appears at start-up.

Top module: `edge_irq_source`

## Requirements
- R1: With the source idle and unmasked, a rising transition on `edge_i` (low for at least three clocks, then high) makes `req_o` go high exactly at the fourth rising clock edge after `edge_i` goes high. This figure assumes the default of two synchroniser stages.
- R2: `req_prio_o` and `req_cpu_o` carry the `prio_cfg_i` and `cpu_cfg_i` values captured when the request was raised. They stay stable while `req_o` is high and read zero while it is low.
- R3: When `accept_i` is sampled with `req_o` high, `req_o` goes low at the next clock edge. It stays low, whatever `edge_i` does, until an EOI is received.
- R4: When `reject_i` is sampled with `req_o` high and `accept_i` low, `req_o` goes low and returns high at exactly `retry_dly_i`+2 clock edges after the edge that sampled the reject. If `accept_i` and `reject_i` are both sampled high together, the accept wins.
- R5: An EOI pulse while in service returns the source to idle. Edges that arrived before the EOI produce no request afterwards. A later edge produces a new request with the latency given in R1.
- R6: An EOI pulse while the source is idle or pending has no effect. An idle source stays silent, and a pending source still raises its request on schedule.
- R7: While `mask_i` is 1, no request is raised. An edge seen while masked is held, and it is discarded when `mask_i` returns to 0, so no request follows.
- R8: Setting `mask_i` while `req_o` is high withdraws the request at the next clock edge. If `accept_i` is sampled in the same cycle, the accept takes effect and the source enters service.
- R9: After reset, `req_o` is 0 and both `req_prio_o` and `req_cpu_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| edge_i | input | 1 | Asynchronous event line; a rising transition is one event |
| mask_i | input | 1 | Explicit mask for bring-up and tear-down |
| prio_cfg_i | input | PRIO_W | Configured priority of the source |
| cpu_cfg_i | input | CPU_W | Configured CPU binding of the source |
| retry_dly_i | input | DLY_W | Back-off in clock cycles after a reject |
| accept_i | input | 1 | Controller took the request |
| reject_i | input | 1 | No CPU could take the request |
| eoi_i | input | 1 | End-of-interrupt strobe |
| req_o | output | 1 | Request toward the controller |
| req_prio_o | output | PRIO_W | Priority carried with the request |
| req_cpu_o | output | CPU_W | CPU binding carried with the request |

## Verification
A wrong internal state shows at the ports almost at once. It appears as a request that is missing, duplicated or late on `req_o`, usually within one to four clocks of the stimulus that exposes it. Latency is therefore measured in exact clock edges: for a fresh edge, for back-off after a reject, and for withdrawal under mask. The state that cannot be seen directly, such as in-service or discarded-pending, is brought out by a follow-up edge or EOI. The request that follows (or its absence) tells which state the source was really in.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  typedef enum logic [2:0] {
    SRC_IDLE  = 3'd0,
    SRC_PEND  = 3'd1,
    SRC_PRES  = 3'd2,
    SRC_INSVC = 3'd3,
    SRC_RETRY = 3'd4
  } src_state_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic rise_o
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  generate
    for (genvar g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= edge_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // Newest synchronised sample high, previous one low.
  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R1: each transition yields a single one-cycle event
  p_rise_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/irq_retry_timer.sv
module irq_retry_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             done_o
);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_en   = load_i | (run_i & ~cnt_zero);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = dly_i;
    else if (run_i)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = run_i & cnt_zero & ~load_i;

  // R4: back-off starts from the programmed value
  p_load_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(dly_i)));

  // R4: back-off counts down one per cycle while waiting
  p_count_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !cnt_zero) |=> (cnt_q == DLY_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
  import irq_src_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int CPU_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              mask_i,
  input  logic              accept_i,
  input  logic              reject_i,
  input  logic              eoi_i,
  input  logic              retry_done_i,
  input  logic [PRIO_W-1:0] prio_cfg_i,
  input  logic [CPU_W-1:0]  cpu_cfg_i,
  output logic              retry_load_o,
  output logic              retry_run_o,
  output logic              req_o,
  output logic [PRIO_W-1:0] req_prio_o,
  output logic [CPU_W-1:0]  req_cpu_o
);

  src_state_e        state_q, state_d;
  logic              mask_q;
  logic              unmask;
  logic              cap_en;
  logic [PRIO_W-1:0] prio_q;
  logic [CPU_W-1:0]  cpu_q;

  assign unmask = mask_q & ~mask_i;

  always_comb begin
    state_d      = state_q;
    retry_load_o = 1'b0;
    unique case (state_q)
      SRC_IDLE: begin
        if (rise_i) state_d = SRC_PEND;
      end
      SRC_PEND: begin
        if (unmask)       state_d = SRC_IDLE;
        else if (!mask_i) state_d = SRC_PRES;
      end
      SRC_PRES: begin
        if (accept_i) begin
          state_d = SRC_INSVC;
        end else if (reject_i) begin
          state_d      = SRC_RETRY;
          retry_load_o = 1'b1;
        end else if (mask_i) begin
          state_d = SRC_PEND;
        end
      end
      SRC_INSVC: begin
        if (eoi_i) state_d = SRC_IDLE;
      end
      SRC_RETRY: begin
        if (unmask)            state_d = SRC_IDLE;
        else if (retry_done_i) state_d = SRC_PEND;
      end
      default: state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRC_IDLE;
      mask_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_i;
    end
  end

  assign cap_en = (state_q == SRC_PEND) & (state_d == SRC_PRES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      cpu_q  <= '0;
    end else if (cap_en) begin
      prio_q <= prio_cfg_i;
      cpu_q  <= cpu_cfg_i;
    end
  end

  assign retry_run_o = (state_q == SRC_RETRY);
  assign req_o       = (state_q == SRC_PRES);
  assign req_prio_o  = req_o ? prio_q : '0;
  assign req_cpu_o   = req_o ? cpu_q  : '0;

  // R3: accepted request moves to service
  p_accept_service_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && accept_i) |=> (state_q == SRC_INSVC));

  // R3: service held until EOI
  p_hold_until_eoi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SRC_INSVC && !eoi_i) |=> (state_q == SRC_INSVC));

  // R4: plain reject enters back-off
  p_reject_backoff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && reject_i && !accept_i) |=> retry_run_o);

  // R5: EOI re-arms to idle
  p_eoi_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SRC_INSVC && eoi_i) |=> (state_q == SRC_IDLE));

  // R7: unmask discards a pending event
  p_unmask_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !mask_i && state_q == SRC_PEND) |=> (state_q == SRC_IDLE));

  // R8: mask withdraws an unanswered request
  p_withdraw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && mask_i && !accept_i && !reject_i) |=> (state_q == SRC_PEND));

  // R2: attributes stable during a request
  p_attr_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> ($stable(req_prio_o) && $stable(req_cpu_o)));

endmodule

// File: rtl/edge_irq_source.sv
module edge_irq_source #(
  parameter int PRIO_W      = 8,
  parameter int CPU_W       = 4,
  parameter int DLY_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              mask_i,
  input  logic [PRIO_W-1:0] prio_cfg_i,
  input  logic [CPU_W-1:0]  cpu_cfg_i,
  input  logic [DLY_W-1:0]  retry_dly_i,
  input  logic              accept_i,
  input  logic              reject_i,
  input  logic              eoi_i,
  output logic              req_o,
  output logic [PRIO_W-1:0] req_prio_o,
  output logic [CPU_W-1:0]  req_cpu_o
);

  logic rst_sync_n;
  logic rise;
  logic retry_load;
  logic retry_run;
  logic retry_done;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge_det (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .edge_i (edge_i),
    .rise_o (rise)
  );

  irq_retry_timer #(.DLY_W(DLY_W)) u_retry_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .load_i (retry_load),
    .run_i  (retry_run),
    .dly_i  (retry_dly_i),
    .done_o (retry_done)
  );

  irq_src_fsm #(.PRIO_W(PRIO_W), .CPU_W(CPU_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .rise_i       (rise),
    .mask_i       (mask_i),
    .accept_i     (accept_i),
    .reject_i     (reject_i),
    .eoi_i        (eoi_i),
    .retry_done_i (retry_done),
    .prio_cfg_i   (prio_cfg_i),
    .cpu_cfg_i    (cpu_cfg_i),
    .retry_load_o (retry_load),
    .retry_run_o  (retry_run),
    .req_o        (req_o),
    .req_prio_o   (req_prio_o),
    .req_cpu_o    (req_cpu_o)
  );

endmodule

// File: tb/edge_irq_source_tb.sv
module edge_irq_source_tb;

  localparam int PRIO_W = 8;
  localparam int CPU_W  = 4;
  localparam int DLY_W  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              edge_i = 1'b0;
  logic              mask_i = 1'b0;
  logic [PRIO_W-1:0] prio_cfg_i = '0;
  logic [CPU_W-1:0]  cpu_cfg_i = '0;
  logic [DLY_W-1:0]  retry_dly_i = '0;
  logic              accept_i = 1'b0;
  logic              reject_i = 1'b0;
  logic              eoi_i = 1'b0;
  logic              req_o;
  logic [PRIO_W-1:0] req_prio_o;
  logic [CPU_W-1:0]  req_cpu_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  edge_irq_source #(.PRIO_W(PRIO_W), .CPU_W(CPU_W), .DLY_W(DLY_W)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (edge_i),
    .mask_i      (mask_i),
    .prio_cfg_i  (prio_cfg_i),
    .cpu_cfg_i   (cpu_cfg_i),
    .retry_dly_i (retry_dly_i),
    .accept_i    (accept_i),
    .reject_i    (reject_i),
    .eoi_i       (eoi_i),
    .req_o       (req_o),
    .req_prio_o  (req_prio_o),
    .req_cpu_o   (req_cpu_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic arm_edge();
    edge_i = 1'b0;
    repeat (3) tick();
    edge_i = 1'b1;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!req_o && n < 40) begin
      tick();
      n++;
    end
  endtask

  task automatic pulse_eoi();
    eoi_i = 1'b1;
    tick();
    eoi_i = 1'b0;
  endtask

  task automatic serve_and_close();
    accept_i = 1'b1;
    tick();
    accept_i = 1'b0;
    pulse_eoi();
    tick();
  endtask

  task automatic t_reset();
    chk("R9 req after reset", int'(req_o), 0);
    chk("R9 prio after reset", int'(req_prio_o), 0);
    chk("R9 cpu after reset", int'(req_cpu_o), 0);
  endtask

  task automatic t_basic();
    int n;
    prio_cfg_i = 8'd5;
    cpu_cfg_i  = 4'd2;
    arm_edge();
    wait_req(n);
    chk("R1 edge-to-request latency", n, 4);
    chk("R2 prio carried", int'(req_prio_o), 5);
    chk("R2 cpu carried", int'(req_cpu_o), 2);
    prio_cfg_i = 8'd9;
    cpu_cfg_i  = 4'd7;
    tick();
    chk("R2 prio stable", int'(req_prio_o), 5);
    chk("R2 cpu stable", int'(req_cpu_o), 2);
    accept_i = 1'b1;
    tick();
    accept_i = 1'b0;
    chk("R3 request drops after accept", int'(req_o), 0);
    chk("R2 prio zero when idle", int'(req_prio_o), 0);
    arm_edge();
    repeat (6) tick();
    chk("R3 edge in service ignored", int'(req_o), 0);
    pulse_eoi();
    repeat (6) tick();
    chk("R5 no replay after eoi", int'(req_o), 0);
    arm_edge();
    wait_req(n);
    chk("R5 rearmed latency", n, 4);
    chk("R2 new prio captured", int'(req_prio_o), 9);
    serve_and_close();
  endtask

  task automatic t_reject();
    int n;
    retry_dly_i = 8'd4;
    arm_edge();
    wait_req(n);
    chk("R4 setup request", int'(req_o), 1);
    reject_i = 1'b1;
    tick();
    reject_i = 1'b0;
    wait_req(n);
    chk("R4 back-off dly=4", n, 6);
    retry_dly_i = 8'd0;
    reject_i = 1'b1;
    tick();
    reject_i = 1'b0;
    wait_req(n);
    chk("R4 back-off dly=0", n, 2);
    accept_i = 1'b1;
    reject_i = 1'b1;
    tick();
    accept_i = 1'b0;
    reject_i = 1'b0;
    repeat (10) tick();
    chk("R4 accept wins over reject", int'(req_o), 0);
    pulse_eoi();
    tick();
    arm_edge();
    wait_req(n);
    chk("R4 service ended by eoi", n, 4);
    serve_and_close();
  endtask

  task automatic t_eoi_idle();
    edge_i = 1'b0;
    repeat (3) tick();
    pulse_eoi();
    repeat (4) tick();
    chk("R6 eoi in idle silent", int'(req_o), 0);
    arm_edge();
    repeat (3) tick();
    chk("R6 still pending", int'(req_o), 0);
    pulse_eoi();
    chk("R6 eoi in pending ignored", int'(req_o), 1);
    serve_and_close();
  endtask

  task automatic t_mask();
    int n;
    mask_i = 1'b1;
    arm_edge();
    repeat (8) tick();
    chk("R7 no request while masked", int'(req_o), 0);
    mask_i = 1'b0;
    repeat (8) tick();
    chk("R7 stale edge discarded", int'(req_o), 0);
    arm_edge();
    wait_req(n);
    chk("R7 fresh edge after unmask", n, 4);
    serve_and_close();
  endtask

  task automatic t_withdraw();
    int n;
    arm_edge();
    wait_req(n);
    mask_i = 1'b1;
    tick();
    chk("R8 withdrawn on mask", int'(req_o), 0);
    mask_i = 1'b0;
    repeat (6) tick();
    chk("R8 withdrawn request discarded", int'(req_o), 0);
    arm_edge();
    wait_req(n);
    chk("R8 re-presented", int'(req_o), 1);
    mask_i = 1'b1;
    accept_i = 1'b1;
    tick();
    accept_i = 1'b0;
    mask_i = 1'b0;
    chk("R8 accept with mask drops req", int'(req_o), 0);
    arm_edge();
    repeat (6) tick();
    chk("R8 accept won, still in service", int'(req_o), 0);
    pulse_eoi();
    tick();
    arm_edge();
    wait_req(n);
    chk("R8 eoi after accept rearms", n, 4);
    serve_and_close();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) tick();
    t_reset();
    t_basic();
    t_reject();
    t_eoi_idle();
    t_mask();
    t_withdraw();
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

endmodule